// File: doc/BRIEF.md
# Uncore Event Counter Unit

This block counts hardware events for performance analysis. It holds eight 48-bit counters, and each counter picks one line out of a 256-wide vector of single-cycle event pulses through an 8-bit event code. A counter advances by one on a cycle where its chosen line pulses, but only while the global run bit and its own enable bit are both set. Code 0xFF parks a counter so that it never advances.

Software reaches the block through a simple memory-mapped register port that accepts one access per cycle and never stalls. Each read is answered one cycle later on a response strobe. Counters occupy 64-bit slots. They can be read or preset as a whole 64-bit word, or as separate 32-bit halves. When a counter steps past its all-ones value it wraps to zero and sets its overflow flag. Software clears an overflow flag by writing a 1 to it. A single level interrupt is raised whenever any flag is set whose mask bit is clear.

Top module: `ecu_unit`

## Requirements
- R1: After reset the registers read as follows: global control 0, counter enables 0, interrupt mask 0xFF, overflow status 0, both event-select registers 0xFFFFFFFF, every counter 0. The interrupt is low.
- R2: Counter n sits in a 64-bit slot at 0x1E00 + 8*n. A 64-bit (wide) access at the slot address reads or writes the whole counter. A 32-bit access at the slot address touches bits 31:0. A 32-bit access at the slot address + 4 touches bits 47:32, carried in data bits 15:0. Bits 63:48 always read as zero, and writing them has no effect.
- R3: The event code for counter n is held in bits [8*(n%4)+7 : 8*(n%4)] of the select register at 0x1D00 (counters 0 to 3) or 0x1D04 (counters 4 to 7). The counter adds one in each cycle where event line [code] is high, and it is not affected by any other event line.
- R4: A counter whose code is 0xFF never advances, whatever the event vector does.
- R5: No counter advances while bit 17 of the control register at 0x0408 is clear.
- R6: Bit n of the enable register at 0x1C00 gates counter n. A counter advances only when its own enable bit and the global bit are both set.
- R7: A counter holding 0xFFFF_FFFF_FFFF that receives an event becomes 0. In the same cycle it sets bit n of the status register at 0x0808.
- R8: The interrupt output is high exactly when some status bit is set and the matching bit of the mask register at 0x0800 is 0. A 1 in the mask silences that bit.
- R9: Writing 1 to bit n of 0x080C clears status bit n. Writing 0 to a bit leaves it unchanged. If an overflow and a clear of the same bit occur in the same cycle, the bit stays set.
- R10: When software writes a counter in the same cycle that the counter receives an event, the written value is what the counter holds afterwards.
- R11: A read request is answered with rsp_valid and the data one cycle after the request is accepted. 32-bit registers return their value in bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request; accepted every cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | 16 | Byte address of the register |
| req_wdata | input | 64 | Write data |
| evt_pulse | input | 256 | Event pulse vector, indexed by event code |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 64 | Read data |
| irq | output | 1 | Level interrupt for unmasked overflows |

## Verification
The bench aims at four corner cases. The first is the carry from bit 31 into the upper half of a counter: a counter that wrongly treated its halves as separate would lose that carry. The second is the wrap at the 48-bit limit, where a design that set the flag one cycle late, or did not wrap to zero, would show a stale status. The third is a collision between a status clear and an overflow of the same bit; a design that gave the clear priority would drop the flag and silently lose an interrupt. The fourth is a collision between a counter write and an event on that counter; here a design that gave the event priority would hold the preset value plus one. The bench also sweeps all eight counters with a different number of pulses each. This exposes a select-field or enable-bit mapping that is shifted by one position, and a parked 0xFF code that is allowed to count line 255.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  localparam logic [15:0] OFS_CTRL = 16'h0408;
  localparam logic [15:0] OFS_MASK = 16'h0800;
  localparam logic [15:0] OFS_STAT = 16'h0808;
  localparam logic [15:0] OFS_CLR  = 16'h080C;
  localparam logic [15:0] OFS_EN   = 16'h1C00;
  localparam logic [15:0] OFS_SEL  = 16'h1D00;
  localparam logic [15:0] OFS_CNT  = 16'h1E00;
  localparam int RUN_BIT        = 17;
  localparam int CODES_PER_SEL  = 4;
  localparam int SEL_STRIDE     = 32 / CODES_PER_SEL;
endpackage

// File: rtl/ecu_slice.sv
module ecu_slice #(
  parameter int CNT_W  = 48,
  parameter int CODE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2**CODE_W-1:0] evt_pulse,
  input  logic [CODE_W-1:0]    code,
  input  logic                 run,
  input  logic                 wr_en,
  input  logic [CNT_W-1:0]     wr_mask,
  input  logic [CNT_W-1:0]     wr_val,
  input  logic                 clr,
  output logic [CNT_W-1:0]     cnt_q,
  output logic                 stat_q
);
  logic hit, wrap;

  // A parked code never counts, even though line [all ones] exists
  assign hit  = run && (code != {CODE_W{1'b1}}) && evt_pulse[code];
  assign wrap = hit && !wr_en && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (wr_en)
        cnt_q <= (cnt_q & ~wr_mask) | (wr_val & wr_mask);
      else if (hit)
        cnt_q <= cnt_q + 1'b1;
      if (wrap)
        stat_q <= 1'b1;
      else if (clr)
        stat_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ecu_readback.sv
module ecu_readback #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 48,
  parameter int CODE_W  = 8,
  localparam int IDX_W  = $clog2(NUM_CNT),
  localparam int NUM_SEL = (NUM_CNT + ecu_pkg::CODES_PER_SEL - 1) / ecu_pkg::CODES_PER_SEL
) (
  input  logic [15:0]               addr,
  input  logic                      in_cnt,
  input  logic [IDX_W-1:0]          cnt_idx,
  input  logic                      hi_half,
  input  logic                      wide,
  input  logic                      run_q,
  input  logic [NUM_CNT-1:0]        en_q,
  input  logic [NUM_CNT-1:0]        mask_q,
  input  logic [NUM_CNT-1:0]        stat_q,
  input  logic [NUM_CNT*CODE_W-1:0] sel_flat,
  input  logic [NUM_CNT*CNT_W-1:0]  cnt_flat,
  output logic [63:0]               rdata
);
  import ecu_pkg::*;
  logic [CNT_W-1:0] cv;

  always_comb begin
    cv    = cnt_flat[cnt_idx*CNT_W +: CNT_W];
    rdata = '0;
    if (in_cnt) begin
      if (hi_half)   rdata = 64'(cv >> 32);
      else if (wide) rdata = 64'(cv);
      else           rdata = 64'(cv[31:0]);
    end else begin
      if (addr == OFS_CTRL) rdata[RUN_BIT]      = run_q;
      if (addr == OFS_EN)   rdata[NUM_CNT-1:0]  = en_q;
      if (addr == OFS_MASK) rdata[NUM_CNT-1:0]  = mask_q;
      if (addr == OFS_STAT) rdata[NUM_CNT-1:0]  = stat_q;
      for (int g = 0; g < NUM_SEL; g++) begin
        if (addr == OFS_SEL + 16'(4 * g)) begin
          rdata[31:0] = '1;
          for (int k = 0; k < CODES_PER_SEL; k++)
            if (g * CODES_PER_SEL + k < NUM_CNT)
              rdata[k*SEL_STRIDE +: SEL_STRIDE] =
                SEL_STRIDE'(sel_flat[(g*CODES_PER_SEL+k)*CODE_W +: CODE_W]);
        end
      end
    end
  end
endmodule

// File: rtl/ecu_unit.sv
module ecu_unit #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 48,
  parameter int CODE_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_wide,
  input  logic [15:0]          req_addr,
  input  logic [63:0]          req_wdata,
  input  logic [2**CODE_W-1:0] evt_pulse,
  output logic                 rsp_valid,
  output logic [63:0]          rsp_rdata,
  output logic                 irq
);
  import ecu_pkg::*;
  localparam int IDX_W   = $clog2(NUM_CNT);
  localparam int HI_W    = CNT_W - 32;
  localparam int NUM_SEL = (NUM_CNT + CODES_PER_SEL - 1) / CODES_PER_SEL;

  logic                      wr, in_cnt, hi_half;
  logic [15:0]               cnt_off;
  logic [IDX_W-1:0]          cnt_idx;
  logic                      run_q;
  logic [NUM_CNT-1:0]        en_q, mask_q, stat_q, clr_vec, wr_hit;
  logic [CODE_W-1:0]         sel_q [NUM_CNT];
  logic [NUM_CNT*CODE_W-1:0] sel_flat;
  logic [NUM_CNT*CNT_W-1:0]  cnt_flat;
  logic [CNT_W-1:0]          wr_mask, wr_val;
  logic [63:0]               rd_next;

  assign wr      = req_valid && req_write;
  assign cnt_off = req_addr - OFS_CNT;
  assign in_cnt  = (req_addr >= OFS_CNT) && (req_addr < OFS_CNT + 16'(8 * NUM_CNT))
                   && (cnt_off[1:0] == 2'b00);
  assign cnt_idx = cnt_off[IDX_W+2:3];
  assign hi_half = cnt_off[2];
  assign clr_vec = (wr && req_addr == OFS_CLR) ? req_wdata[NUM_CNT-1:0] : '0;

  // Which bits of the counter a write touches and where the data lands
  always_comb begin
    if (hi_half) begin
      wr_mask = {{HI_W{1'b1}}, 32'h0};
      wr_val  = {req_wdata[HI_W-1:0], 32'h0};
    end else if (req_wide) begin
      wr_mask = '1;
      wr_val  = req_wdata[CNT_W-1:0];
    end else begin
      wr_mask = {{HI_W{1'b0}}, 32'hFFFF_FFFF};
      wr_val  = {{HI_W{1'b0}}, req_wdata[31:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      en_q   <= '0;
      mask_q <= '1;
      for (int i = 0; i < NUM_CNT; i++) sel_q[i] <= '1;
    end else if (wr) begin
      if (req_addr == OFS_CTRL) run_q  <= req_wdata[RUN_BIT];
      if (req_addr == OFS_EN)   en_q   <= req_wdata[NUM_CNT-1:0];
      if (req_addr == OFS_MASK) mask_q <= req_wdata[NUM_CNT-1:0];
      for (int g = 0; g < NUM_SEL; g++)
        if (req_addr == OFS_SEL + 16'(4 * g))
          for (int k = 0; k < CODES_PER_SEL; k++)
            if (g * CODES_PER_SEL + k < NUM_CNT)
              sel_q[g*CODES_PER_SEL+k] <= req_wdata[k*SEL_STRIDE +: CODE_W];
    end
  end

  generate
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_slice
      assign wr_hit[i] = wr && in_cnt && (cnt_idx == IDX_W'(i));
      assign sel_flat[i*CODE_W +: CODE_W] = sel_q[i];
      ecu_slice #(.CNT_W(CNT_W), .CODE_W(CODE_W)) i_slice (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_pulse(evt_pulse),
        .code     (sel_q[i]),
        .run      (run_q && en_q[i]),
        .wr_en    (wr_hit[i]),
        .wr_mask  (wr_mask),
        .wr_val   (wr_val),
        .clr      (clr_vec[i]),
        .cnt_q    (cnt_flat[i*CNT_W +: CNT_W]),
        .stat_q   (stat_q[i])
      );
    end
  endgenerate

  ecu_readback #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .CODE_W(CODE_W)) i_readback (
    .addr    (req_addr),
    .in_cnt  (in_cnt),
    .cnt_idx (cnt_idx),
    .hi_half (hi_half),
    .wide    (req_wide),
    .run_q   (run_q),
    .en_q    (en_q),
    .mask_q  (mask_q),
    .stat_q  (stat_q),
    .sel_flat(sel_flat),
    .cnt_flat(cnt_flat),
    .rdata   (rd_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_next;
    end
  end

  assign irq = |(stat_q & ~mask_q);
endmodule

// File: rtl/ecu_checker.sv
module ecu_checker #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 48,
  parameter int CODE_W  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_write,
  input logic [15:0]               req_addr,
  input logic [63:0]               req_wdata,
  input logic                      rsp_valid,
  input logic                      irq,
  input logic                      run_q,
  input logic [NUM_CNT-1:0]        en_q,
  input logic [NUM_CNT-1:0]        stat_q,
  input logic [NUM_CNT-1:0]        wr_hit,
  input logic [NUM_CNT*CODE_W-1:0] sel_flat,
  input logic [NUM_CNT*CNT_W-1:0]  cnt_flat
);
  import ecu_pkg::*;

  a_r11_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  a_r8_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (stat_q != '0));

  generate
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
      a_r5_r6_hold_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run_q && en_q[i]) && !wr_hit[i]) |=>
          $stable(cnt_flat[i*CNT_W +: CNT_W]));

      a_r4_parked_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_flat[i*CODE_W +: CODE_W] == {CODE_W{1'b1}}) && !wr_hit[i]) |=>
          $stable(cnt_flat[i*CNT_W +: CNT_W]));

      a_r7_flag_rises_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[i]) |-> (cnt_flat[i*CNT_W +: CNT_W] == '0));

      a_r9_flag_falls_only_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[i]) |->
          $past(req_valid && req_write && req_addr == OFS_CLR && req_wdata[i]));
    end
  endgenerate
endmodule

bind ecu_unit ecu_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .CODE_W(CODE_W)) i_ecu_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .irq      (irq),
  .run_q    (run_q),
  .en_q     (en_q),
  .stat_q   (stat_q),
  .wr_hit   (wr_hit),
  .sel_flat (sel_flat),
  .cnt_flat (cnt_flat)
);

// File: tb/test_ecu_unit.sv
module test_ecu_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [15:0]  req_addr = '0;
  logic [63:0]  req_wdata = '0;
  logic [255:0] evt_pulse = '0;
  logic         rsp_valid, irq;
  logic [63:0]  rsp_rdata;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  code [8];
  logic [63:0] expv [8];
  logic [63:0] rv;
  localparam logic [63:0] MAX48 = 64'h0000_FFFF_FFFF_FFFF;

  always #2 clk = ~clk;

  ecu_unit i_ecu_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .evt_pulse(evt_pulse), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d, input logic w);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_wide = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic w, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_wide = w; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk("R11 rsp_valid", 64'(rsp_valid), 64'd1);
    d = rsp_rdata;
  endtask

  task automatic pulse(input logic [255:0] v);
    @(negedge clk);
    evt_pulse = v;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  function automatic logic [15:0] caddr(input int n);
    return 16'h1E00 + 16'(8 * n);
  endfunction

  initial begin
    #(4 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [255:0] v;
    for (int n = 0; n < 8; n++) code[n] = 8'(n * 29 + 7);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 irq", 64'(irq), 0);
    rd(16'h0408, 0, rv); chk("R1 ctrl", rv, 0);
    rd(16'h1C00, 0, rv); chk("R1 enable", rv, 0);
    rd(16'h0800, 0, rv); chk("R1 mask", rv, 64'hFF);
    rd(16'h0808, 0, rv); chk("R1 status", rv, 0);
    rd(16'h1D00, 0, rv); chk("R1 sel0", rv, 64'hFFFF_FFFF);
    rd(16'h1D04, 0, rv); chk("R1 sel1", rv, 64'hFFFF_FFFF);
    rd(caddr(4), 1, rv); chk("R1 counter4", rv, 0);

    // R2 wide write ignores bits 63:48
    wr(caddr(7), 64'hFFFF_0000_0000_0001, 1);
    rd(caddr(7), 1, rv); chk("R2 upper bits ignored", rv, 64'h1);

    // R3 select programming
    wr(16'h1D00, {32'h0, code[3], code[2], code[1], code[0]}, 0);
    wr(16'h1D04, {32'h0, code[7], code[6], code[5], code[4]}, 0);
    rd(16'h1D04, 0, rv); chk("R3 sel1 readback", rv, {32'h0, code[7], code[6], code[5], code[4]});

    // R2 narrow presets straddling the 32-bit boundary
    for (int n = 0; n < 8; n++) begin
      wr(caddr(n), 64'h5555_5555_FFFF_FFFE, 0);
      wr(caddr(n) + 16'd4, 64'hFFFF_FFFF_FFFF_0000 | 64'(n), 0);
      expv[n] = (64'(n) << 32) + 64'hFFFF_FFFE;
    end
    rd(caddr(3) + 16'd4, 0, rv); chk("R2 high half read", rv, 64'd3);

    // R3 R6 sweep: counter n gets n+1 pulses, line 255 always high
    wr(16'h1C00, 64'hFF, 0);
    wr(16'h0408, 64'h2_0000, 0);
    for (int p = 0; p < 8; p++) begin
      v = '0; v[255] = 1'b1;
      for (int n = 0; n < 8; n++) if (n >= p) v[code[n]] = 1'b1;
      pulse(v);
    end
    for (int n = 0; n < 8; n++) begin
      expv[n] = expv[n] + 64'(n + 1);
      rd(caddr(n), 1, rv); chk($sformatf("R3 sweep counter%0d", n), rv, expv[n]);
    end
    rd(caddr(6), 0, rv); chk("R2 low half after carry", rv, expv[6] & 64'hFFFF_FFFF);

    // R5 global run off
    wr(16'h0408, 64'h0, 0);
    pulse('1);
    rd(caddr(3), 1, rv); chk("R5 no count when global off", rv, expv[3]);

    // R6 per-counter enable
    wr(16'h0408, 64'h2_0000, 0);
    wr(16'h1C00, 64'hFE, 0);
    pulse('1);
    for (int n = 1; n < 8; n++) expv[n] = expv[n] + 1;
    rd(caddr(0), 1, rv); chk("R6 disabled counter0 holds", rv, expv[0]);
    rd(caddr(1), 1, rv); chk("R6 enabled counter1 counts", rv, expv[1]);

    // R4 parked code on counter 2
    wr(16'h1D00, {32'h0, code[3], 8'hFF, code[1], code[0]}, 0);
    pulse('1);
    for (int n = 1; n < 8; n++) if (n != 2) expv[n] = expv[n] + 1;
    rd(caddr(2), 1, rv); chk("R4 parked counter holds", rv, expv[2]);
    rd(caddr(3), 1, rv); chk("R4 neighbour still counts", rv, expv[3]);

    // R7 R8 overflow and interrupt masking
    wr(16'h0800, 64'hDF, 0);
    wr(caddr(5), MAX48, 1);
    wr(caddr(6), MAX48, 1);
    v = '0; v[code[5]] = 1'b1; v[code[6]] = 1'b1;
    pulse(v);
    rd(caddr(5), 1, rv); chk("R7 wrap to zero", rv, 0);
    rd(16'h0808, 0, rv); chk("R7 status set", rv, 64'h60);
    chk("R8 irq unmasked", 64'(irq), 1);

    // R9 clears
    wr(16'h080C, 64'h0, 0);
    rd(16'h0808, 0, rv); chk("R9 zero write no effect", rv, 64'h60);
    wr(16'h080C, 64'h20, 0);
    rd(16'h0808, 0, rv); chk("R9 clear bit5", rv, 64'h40);
    chk("R8 irq masked bit only", 64'(irq), 0);
    wr(16'h080C, 64'h40, 0);
    rd(16'h0808, 0, rv); chk("R9 clear bit6", rv, 0);

    // R9 overflow and clear in the same cycle
    wr(caddr(5), MAX48, 1);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_wide = 0; req_addr = 16'h080C; req_wdata = 64'h20;
    evt_pulse = '0; evt_pulse[code[5]] = 1'b1;
    @(negedge clk);
    req_valid = 0; req_write = 0; evt_pulse = '0;
    rd(16'h0808, 0, rv); chk("R9 overflow beats clear", rv, 64'h20);
    chk("R8 irq after collision", 64'(irq), 1);

    // R10 write beats event
    @(negedge clk);
    req_valid = 1; req_write = 1; req_wide = 1; req_addr = caddr(1); req_wdata = 64'd100;
    evt_pulse = '0; evt_pulse[code[1]] = 1'b1;
    @(negedge clk);
    req_valid = 0; req_write = 0; evt_pulse = '0;
    rd(caddr(1), 1, rv); chk("R10 write priority", rv, 64'd100);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule